// File: doc/BRIEF.md
# FIFO Flag Offset Register Loader

This block holds the two programmable thresholds of a synchronous FIFO: the almost-empty offset and the almost-full offset. Both are written over a narrow parallel data bus through a fixed series of bus cycles, and read back over the same kind of bus through the same series. Each load strobe or read strobe moves the block one step through the series. The steps cover the empty offset first, then the full offset, and the position then returns to the start.

The number of steps and the placement of bits within each step depend on three things. The first is the bus width (9-bit or 18-bit, set separately for the write side and the read side). The second is a depth parameter that sets the offset width. The third is a mode that leaves bus bit 8 free for a parity bit. On a 9-bit bus, eight offset bits move per step, least significant lane first. On an 18-bit bus, a whole offset moves in one step. Offset bits above the configured width read as zero, and bus bits that carry no offset bit are driven to zero on read-back.

Top module: `ofs_loader`

## Requirements
- R1: While reset is held and right after it, the sequence position is the first empty-offset step, `empty_ofs` shows `EMPTY_RST` and `full_ofs` shows `FULL_RST`, each masked to the active offset width.
- R2: The active offset width is 9 + `DEPTH_SEL` bits, or 10 + `DEPTH_SEL` bits when both `wr_wide` and `rd_wide` are 0. Offset bits at or above that width always read as zero on `empty_ofs`, `full_ofs` and `bus_out`.
- R3: With `wr_wide`=1, every load writes a whole register and moves to the other register. The empty offset is written first, then the full offset, and after the full offset the position returns to the empty offset.
- R4: In 18-bit transfers with `par_gap`=1, bus bit 8 carries no offset bit: offset bits 7..0 sit on bus 7..0 and offset bits 15..8 sit on bus 16..9. With `par_gap`=0, offset bit i sits on bus bit i.
- R5: With `wr_wide`=0, each load writes `bus_in[7:0]` into one 8-bit lane of the current register (lane k holds offset bits 8k+7..8k), and bits 17..8 are ignored. A register takes 3 lanes when the active width is 17 bits and 2 lanes otherwise, so a full pass is 6 or 4 steps.
- R6: `bus_out` presents the current step's register content with the same lane or packing rules as a write on a bus of width `rd_wide`. Each read strobe advances the position as a load on that width would.
- R7: Bus bits on `bus_out` that carry no offset bit are zero: bits 17..8 when `rd_wide`=0, and bits 8 and 17 for an 18-bit read with `par_gap`=1.
- R8: When `ld_stb` and `rd_stb` are both high, the load is performed and the position advances once, as set by `wr_wide`.
- R9: Without `ld_stb` the offsets hold. Without either strobe the sequence position holds.
- R10: With mixed bus widths (one side 9-bit, the other 18-bit), the offset width is 9 + `DEPTH_SEL`, so a 9-bit load pass takes 2 lanes per register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_stb | input | 1 | Load one step from `bus_in` |
| rd_stb | input | 1 | Advance the read-back step |
| wr_wide | input | 1 | Write bus is 18-bit (1) or 9-bit (0) |
| rd_wide | input | 1 | Read bus is 18-bit (1) or 9-bit (0) |
| par_gap | input | 1 | Bus bit 8 reserved for parity in 18-bit transfers |
| bus_in | input | 18 | Write data bus |
| bus_out | output | 18 | Read-back data for the current step |
| empty_ofs | output | 17 | Almost-empty offset, masked to the active width |
| full_ofs | output | 17 | Almost-full offset, masked to the active width |

## Verification
The assertions check the following on every cycle:
- The position is cleared by reset.
- The offsets and the position hold without strobes.
- An 18-bit load always lands on lane 0 of the other register.
- A finished pass returns to the empty register.
- The read bus keeps its unused bits at zero in both 9-bit and parity-gap packing.

Only the bench scenarios can show that the data values are right. This covers lane placement, the 6-step pass at 17-bit width, the parity-gap bit shuffle, the mixed-width offset width and the result of a load and a read strobed together. The bench checks these against its own bit-by-bit model of registers and position.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int OFS_W  = 17;  // widest offset
  localparam int BUS_W  = 18;  // data bus width
  localparam int LANE_W = 8;   // offset bits per 9-bit step

  // active offset width: one extra bit when both sides run 9-bit
  function automatic int ofs_width(int depth_sel, logic wr_wide, logic rd_wide);
    return 9 + depth_sel + ((!wr_wide && !rd_wide) ? 1 : 0);
  endfunction

  function automatic logic [OFS_W-1:0] width_mask(int w);
    logic [OFS_W-1:0] m;
    for (int i = 0; i < OFS_W; i++) m[i] = (i < w);
    return m;
  endfunction

  // index of the last 9-bit lane of one register
  function automatic logic [1:0] last_lane(int w);
    return (w > 2 * LANE_W) ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [OFS_W-1:0] wide_unpack(logic [BUS_W-1:0] b, logic gap);
    return gap ? {b[17], b[16:9], b[7:0]} : b[16:0];
  endfunction

  function automatic logic [BUS_W-1:0] wide_pack(logic [OFS_W-1:0] v, logic gap);
    return gap ? {v[16], v[15:8], 1'b0, v[7:0]} : {1'b0, v[16:0]};
  endfunction
endpackage

// File: rtl/ofs_seq.sv
module ofs_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       step_wide,
  input  logic [1:0] last,
  output logic       sel,
  output logic [1:0] lane,
  output logic       wrap
);
  logic reg_done;
  assign reg_done = step_wide || (lane >= last);
  assign wrap     = step && sel && reg_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= 1'b0;
      lane <= 2'd0;
    end else if (step) begin
      if (reg_done) begin
        lane <= 2'd0;
        sel  <= ~sel;
      end else begin
        lane <= lane + 2'd1;
      end
    end
  end
endmodule

// File: rtl/ofs_wr_merge.sv
module ofs_wr_merge
  import ofs_pkg::*;
(
  input  logic [OFS_W-1:0] old_val,
  input  logic [BUS_W-1:0] bus,
  input  logic [1:0]       lane,
  input  logic             wide,
  input  logic             gap,
  output logic [OFS_W-1:0] new_val
);
  always_comb begin
    new_val = old_val;
    if (wide) begin
      new_val = wide_unpack(bus, gap);
    end else begin
      case (lane)
        2'd0:    new_val[7:0]  = bus[7:0];
        2'd1:    new_val[15:8] = bus[7:0];
        default: new_val[16]   = bus[0];
      endcase
    end
  end
endmodule

// File: rtl/ofs_rd_format.sv
module ofs_rd_format
  import ofs_pkg::*;
(
  input  logic [OFS_W-1:0] val,
  input  logic [1:0]       lane,
  input  logic             wide,
  input  logic             gap,
  output logic [BUS_W-1:0] bus
);
  always_comb begin
    if (wide) begin
      bus = wide_pack(val, gap);
    end else begin
      case (lane)
        2'd0:    bus = {10'd0, val[7:0]};
        2'd1:    bus = {10'd0, val[15:8]};
        default: bus = {17'd0, val[16]};
      endcase
    end
  end
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_pkg::*;
#(
  parameter int               DEPTH_SEL = 7,
  parameter logic [OFS_W-1:0] EMPTY_RST = 17'h0007F,
  parameter logic [OFS_W-1:0] FULL_RST  = 17'h0007F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_stb,
  input  logic             rd_stb,
  input  logic             wr_wide,
  input  logic             rd_wide,
  input  logic             par_gap,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] bus_out,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);
  // named internal events, observed by the bound checker
  int               act_w;
  logic [OFS_W-1:0] act_mask;
  logic [1:0]       lane_last;
  logic             step, step_wide;
  logic             pos_sel, wrap_evt;
  logic [1:0]       pos_chunk;
  logic [OFS_W-1:0] empty_q, full_q, cur_val, merged;

  assign act_w     = ofs_width(DEPTH_SEL, wr_wide, rd_wide);
  assign act_mask  = width_mask(act_w);
  assign lane_last = last_lane(act_w);
  assign step      = ld_stb || rd_stb;
  assign step_wide = ld_stb ? wr_wide : rd_wide;  // load wins (R8)

  ofs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .step(step), .step_wide(step_wide),
    .last(lane_last), .sel(pos_sel), .lane(pos_chunk), .wrap(wrap_evt)
  );

  assign empty_ofs = empty_q & act_mask;
  assign full_ofs  = full_q & act_mask;
  assign cur_val   = pos_sel ? full_ofs : empty_ofs;

  ofs_wr_merge u_wr (
    .old_val(cur_val), .bus(bus_in), .lane(pos_chunk),
    .wide(wr_wide), .gap(par_gap), .new_val(merged)
  );

  ofs_rd_format u_rd (
    .val(cur_val), .lane(pos_chunk), .wide(rd_wide),
    .gap(par_gap), .bus(bus_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= EMPTY_RST;
      full_q  <= FULL_RST;
    end else if (ld_stb) begin
      if (pos_sel) full_q <= merged;
      else         empty_q <= merged;
    end
  end
endmodule

// File: rtl/ofs_chk.sv
module ofs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ld_stb,
  input logic        rd_stb,
  input logic        wr_wide,
  input logic        rd_wide,
  input logic        par_gap,
  input logic [17:0] bus_out,
  input logic [16:0] empty_ofs,
  input logic [16:0] full_ofs,
  input logic        pos_sel,
  input logic [1:0]  pos_chunk,
  input logic        wrap_evt
);
  assert_reset_pos_R1: assert property (@(posedge clk)
    !rst_n |=> (!pos_sel && pos_chunk == 2'd0));

  assert_ofs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_stb |=> ($stable(empty_ofs) && $stable(full_ofs)));

  assert_pos_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_stb || rd_stb) |=> ($stable(pos_sel) && $stable(pos_chunk)));

  assert_wide_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && wr_wide) |=> (pos_chunk == 2'd0 && pos_sel != $past(pos_sel)));

  assert_pass_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (!pos_sel && pos_chunk == 2'd0));

  assert_lane_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pos_chunk != 2'd3);

  assert_narrow_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_wide |-> (bus_out[17:8] == 10'd0));

  assert_gap_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_wide && par_gap) |-> (!bus_out[8] && !bus_out[17]));
endmodule

bind ofs_loader ofs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .rd_stb(rd_stb),
  .wr_wide(wr_wide), .rd_wide(rd_wide), .par_gap(par_gap),
  .bus_out(bus_out), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
  .pos_sel(pos_sel), .pos_chunk(pos_chunk), .wrap_evt(wrap_evt)
);

// File: tb/sim_ofs_loader.sv
`timescale 1ns/1ps
module sim_ofs_loader;
  localparam int          SEL   = 7;
  localparam logic [16:0] E_DEF = 17'h1A5C3;
  localparam logic [16:0] F_DEF = 17'h0E71B;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_stb = 1'b0, rd_stb = 1'b0;
  logic wr_wide = 1'b0, rd_wide = 1'b0, par_gap = 1'b0;
  logic [17:0] bus_in = '0, bus_out;
  logic [16:0] empty_ofs, full_ofs;

  int checks = 0, errors = 0;
  logic [16:0] me, mf;
  bit msel;
  int mlane;

  always #2.5 clk = ~clk;

  ofs_loader #(.DEPTH_SEL(SEL), .EMPTY_RST(E_DEF), .FULL_RST(F_DEF)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .rd_stb(rd_stb),
    .wr_wide(wr_wide), .rd_wide(rd_wide), .par_gap(par_gap),
    .bus_in(bus_in), .bus_out(bus_out), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  function automatic int bw();
    return (wr_wide || rd_wide) ? 9 + SEL : 10 + SEL;
  endfunction

  function automatic logic [16:0] keep(logic [16:0] v, int w);
    logic [16:0] r = '0;
    for (int i = 0; i < w && i < 17; i++) r[i] = v[i];
    return r;
  endfunction

  function automatic int lanes(int w);
    return (w + 7) / 8;
  endfunction

  function automatic logic [17:0] exp_out();
    logic [16:0] v = keep(msel ? mf : me, bw());
    logic [17:0] d = '0;
    int idx = 0;
    if (rd_wide) begin
      for (int p = 0; p < 18; p++) begin
        if (par_gap && p == 8) continue;
        if (idx < 17) d[p] = v[idx];
        idx++;
      end
    end else begin
      for (int i = 0; i < 8; i++)
        if (8 * mlane + i < 17) d[i] = v[8 * mlane + i];
    end
    return d;
  endfunction

  task automatic model_load(input logic [17:0] d);
    logic [16:0] v = msel ? mf : me;
    int w = bw();
    int idx = 0;
    if (wr_wide) begin
      for (int p = 0; p < 18; p++) begin
        if (par_gap && p == 8) continue;
        if (idx < w) v[idx] = d[p];
        idx++;
      end
    end else begin
      for (int i = 0; i < 8; i++)
        if (8 * mlane + i < w) v[8 * mlane + i] = d[i];
    end
    if (msel) mf = v; else me = v;
  endtask

  task automatic model_step(input bit wide);
    if (wide || mlane + 1 >= lanes(bw())) begin
      mlane = 0;
      msel  = !msel;
    end else begin
      mlane++;
    end
  endtask

  task automatic chk(input logic [17:0] act, input logic [17:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit ww, input bit rw, input bit g);
    @(negedge clk);
    rst_n = 1'b0; ld_stb = 1'b0; rd_stb = 1'b0;
    wr_wide = ww; rd_wide = rw; par_gap = g;
    me = E_DEF; mf = F_DEF; msel = 0; mlane = 0;
    repeat (2) @(negedge clk);
    chk({1'b0, empty_ofs}, {1'b0, keep(E_DEF, bw())}, "R1 empty default");
    chk({1'b0, full_ofs},  {1'b0, keep(F_DEF, bw())}, "R1 full default");
    chk(bus_out, exp_out(), "R1 first step readback");
    rst_n = 1'b1;
  endtask

  task automatic step(input bit ld, input bit rd, input logic [17:0] d);
    string tag;
    @(negedge clk);
    ld_stb = ld; rd_stb = rd; bus_in = d;
    #1;
    chk(bus_out, exp_out(), rd_wide ? "R6 readback" : "R7 readback narrow");
    if (ld) model_load(d);
    if (ld || rd) model_step(ld ? wr_wide : rd_wide);
    if (ld && rd)             tag = "R8 load priority";
    else if (!ld)             tag = "R9 hold";
    else if (wr_wide != rd_wide) tag = "R10 mixed width";
    else if (wr_wide)         tag = "R3 wide load";
    else                      tag = "R5 lane load";
    @(posedge clk);
    #1;
    ld_stb = 1'b0; rd_stb = 1'b0;
    chk({1'b0, empty_ofs}, {1'b0, keep(me, bw())}, tag);
    chk({1'b0, full_ofs},  {1'b0, keep(mf, bw())}, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));

    // 9-bit both sides: 17-bit offset, three lanes per register
    do_reset(0, 0, 0);
    chk({1'b0, empty_ofs}, {1'b0, 17'h1A5C3}, "R2 width 17 keeps bit 16");
    step(1, 0, 18'h3FF12); step(1, 0, 18'h3FF34); step(1, 0, 18'h3FF01);
    step(1, 0, 18'h00056); step(1, 0, 18'h00078); step(1, 0, 18'h00000);
    chk({1'b0, empty_ofs}, {1'b0, 17'h13412}, "R5 six-step pass empty");
    chk({1'b0, full_ofs},  {1'b0, 17'h07856}, "R5 six-step pass full");
    for (int i = 0; i < 6; i++) step(0, 1, '0);

    // 18-bit with parity gap
    do_reset(1, 1, 1);
    chk({1'b0, empty_ofs}, {1'b0, 17'h0A5C3}, "R2 width 16 masks bit 16");
    step(1, 0, 18'h34B3C);
    chk({1'b0, empty_ofs}, {1'b0, 17'h0A53C}, "R4 gap unpack");
    step(0, 1, '0);
    step(0, 1, '0);
    step(1, 1, 18'h0BEEF);

    // mixed widths
    do_reset(0, 1, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 18'($urandom()));
    step(0, 1, '0); step(0, 1, '0);
    do_reset(1, 0, 1);
    for (int i = 0; i < 3; i++) step(1, 0, 18'($urandom()));
    for (int i = 0; i < 5; i++) step(0, 1, '0);

    // constrained random segments
    for (int s = 0; s < 12; s++) begin
      do_reset(1'($urandom()), 1'($urandom()), 1'($urandom()));
      for (int i = 0; i < 30; i++)
        step(($urandom() % 3) == 0, ($urandom() % 3) == 0, 18'($urandom()));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule